// File: doc/BRIEF.md
# One-Bit Quadrature Mixer Counter

This block takes a one-bit stream from a comparator, one sample per clock, and mixes it with two square-wave local oscillators a quarter cycle apart. Each oscillator bit is the top bit of a 32-bit phase accumulator that advances by a programmable step on every sample. The mixer is an exclusive-OR, so no multipliers are used. The mixed bits are packed 32 to a word, and each finished word is integrated by counting its ones into a pair of down-counters per channel. One counter takes a weight of two and the other a weight of one.

A snapshot strobe copies both channels' counter pairs into output words on the same edge. Logic after the block differences successive snapshots modulo 2^16 to recover an integrated sample: twice the fall in the weight-2 count plus the fall in the weight-1 count. The strobe is normally pulsed at four times the final output rate. The tuning step is the wanted frequency times 2^32 divided by the sample clock. The block uses the step exactly as written. Rounding the frequency so that the oscillator pattern repeats is left to whatever computes the step.

Top module: `onebit_qmix`

## Requirements
- R1: Each oscillator bit is bit 31 of its phase register. At every clock that does not load a new tuning step, each phase register gains the current step, modulo 2^32.
- R2: After reset and after every tuning load, the cosine phase is 0xC0000000 and the sine phase is 0x00000000.
- R3: Each input bit is XORed with the cosine bit for channel I and with the sine bit for channel Q. Mixed bits are packed 32 per word, with the oldest bit in bit 31. A word is complete on every 32nd clock after reset.
- R4: On the edge that completes a word, each nibble of the word (bits 31:28, 27:24, and so on down to 3:0) with popcount p lowers the weight-2 counter by p/2 (rounded down) and the weight-1 counter by p mod 2. Both counters are 16 bits wide and wrap modulo 2^16.
- R5: The counters do not change on any edge that does not complete a word.
- R6: When snap is high at an edge, snap_i becomes {I weight-2, I weight-1} and snap_q becomes {Q weight-2, Q weight-1}. The weight-2 count is in bits 31:16 and the weight-1 count in bits 15:0. The values are those held before that edge's update. snap_vld is high for exactly the cycle after each edge where snap is high.
- R7: Both channels are captured on the same edge, so both snapshot words cover the same run of input bits.
- R8: A tuning write is held pending and takes effect only on the edge that completes a word. A later write replaces an earlier pending one. A write made in the cycle that completes a word waits for the next completing edge.
- R9: Reset (active high, synchronous) clears all four counters and both snapshot words, clears snap_vld, and sets the step to the INIT_STEP parameter with both phases at their starting values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| rf_bit | input | 1 | One-bit input sample |
| tune_we | input | 1 | Write strobe for the tuning step |
| tune_step | input | 32 | New phase step |
| snap | input | 1 | Snapshot strobe |
| snap_vld | output | 1 | High for one cycle when the snapshot words are new |
| snap_i | output | 32 | Channel I counter pair, weight-2 in 31:16, weight-1 in 15:0 |
| snap_q | output | 32 | Channel Q counter pair, same layout |

## Verification
The assertions assume that rf_bit, tune_we, tune_step and snap are stable across each rising edge and free of X. They also assume that reset is held long enough to clear the word position counter, because word completion is derived from that counter alone. The bench drives every input on the falling edge from its own tasks and keeps reset high for several cycles. It places tuning writes both in the middle of a word and exactly on a completing cycle, and it pulses snap singly, back to back, and on word boundaries. That covers the pending-load rule and the pre-update capture without ever moving an input near the sampling edge.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  localparam logic [31:0] QM_COS_START = 32'hC000_0000;
  localparam logic [31:0] QM_SIN_START = 32'h0000_0000;

  // ones in a 4-bit group
  function automatic logic [2:0] nib_pop(input logic [3:0] n);
    nib_pop = 3'(n[0]) + 3'(n[1]) + 3'(n[2]) + 3'(n[3]);
  endfunction

  // weight-2 share of a nibble popcount
  function automatic logic [1:0] pop_twos(input logic [2:0] p);
    pop_twos = p[2:1];
  endfunction

  // weight-1 share of a nibble popcount
  function automatic logic pop_ones(input logic [2:0] p);
    pop_ones = p[0];
  endfunction
endpackage

// File: rtl/qmix_nco.sv
module qmix_nco #(
  parameter int PW = 32,
  parameter logic [PW-1:0] START = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [PW-1:0] step,
  output logic          lo_bit
);
  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || load) phase <= START;
    else             phase <= phase + step;
  end

  assign lo_bit = phase[PW-1];

  // R2: a load puts the phase back at its start value
  assert_phase_start_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (phase == START));
  // R1: without a load the phase moves by exactly one step
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    !load |=> (phase == $past(phase) + $past(step)));
endmodule

// File: rtl/qmix_tally.sv
module qmix_tally
  import qmix_pkg::*;
#(
  parameter int WW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mix_bit,
  input  logic          word_done,
  output logic [CW-1:0] cnt_two,
  output logic [CW-1:0] cnt_one
);
  localparam int NN = WW / 4;

  logic [WW-2:0] hist;
  logic [WW-1:0] word;
  logic [2:0]    pops [NN];
  logic [CW-1:0] dec_two, dec_one, pop_total;

  assign word = {hist, mix_bit};

  generate
    for (genvar n = 0; n < NN; n++) begin : g_nib
      assign pops[n] = nib_pop(word[4*n+3 : 4*n]);
    end
  endgenerate

  always_comb begin
    dec_two   = '0;
    dec_one   = '0;
    pop_total = '0;
    for (int n = 0; n < NN; n++) begin
      dec_two   = dec_two + CW'(pop_twos(pops[n]));
      dec_one   = dec_one + CW'(pop_ones(pops[n]));
      pop_total = pop_total + CW'(pops[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      cnt_two <= '0;
      cnt_one <= '0;
    end else begin
      hist <= {hist[WW-3:0], mix_bit};
      if (word_done) begin
        cnt_two <= cnt_two - dec_two;
        cnt_one <= cnt_one - dec_one;
      end
    end
  end

  // R5: counters are frozen between word completions
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !word_done |=> ($stable(cnt_two) && $stable(cnt_one)));
  // R4: the weighted fall of the pair equals the word's popcount
  assert_weighted_fall_R4: assert property (@(posedge clk) disable iff (rst)
    word_done |=> ((CW'(($past(cnt_two) - cnt_two) << 1) + CW'($past(cnt_one) - cnt_one))
                   == $past(pop_total)));
endmodule

// File: rtl/qmix_tune.sv
module qmix_tune #(
  parameter int PW = 32,
  parameter logic [PW-1:0] INIT_STEP = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          tune_we,
  input  logic [PW-1:0] tune_step,
  output logic [PW-1:0] step,
  output logic          load
);
  logic          pend;
  logic [PW-1:0] pend_step;

  assign load = boundary && pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      pend_step <= '0;
      step      <= INIT_STEP;
    end else begin
      if (load)    step <= pend_step;
      if (tune_we) begin
        pend      <= 1'b1;
        pend_step <= tune_step;
      end else if (load) begin
        pend <= 1'b0;
      end
    end
  end

  // R8: the step moves only on a word-completing edge
  assert_step_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(step));
  // R8: a write never lands in the same cycle it arrives
  assert_write_deferred_R8: assert property (@(posedge clk) disable iff (rst)
    (tune_we && !load) |=> $stable(step));
endmodule

// File: rtl/onebit_qmix.sv
module onebit_qmix
  import qmix_pkg::*;
#(
  parameter int PW = 32,
  parameter int WW = 32,
  parameter int CW = 16,
  parameter logic [31:0] INIT_STEP = 32'h1000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rf_bit,
  input  logic          tune_we,
  input  logic [31:0]   tune_step,
  input  logic          snap,
  output logic          snap_vld,
  output logic [31:0]   snap_i,
  output logic [31:0]   snap_q
);
  localparam int POS_W = $clog2(WW);
  localparam int SW    = 2 * CW;

  logic [POS_W-1:0] pos;
  logic             word_done;
  logic             load;
  logic [PW-1:0]    step;
  logic             lo_bit  [2];
  logic             mix_bit [2];
  logic [CW-1:0]    c_two   [2];
  logic [CW-1:0]    c_one   [2];

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= (pos == POS_W'(WW - 1)) ? '0 : pos + 1'b1;
  end
  assign word_done = (pos == POS_W'(WW - 1));

  qmix_tune #(.PW(PW), .INIT_STEP(PW'(INIT_STEP))) u_tune (
    .clk(clk), .rst(rst), .boundary(word_done), .tune_we(tune_we),
    .tune_step(PW'(tune_step)), .step(step), .load(load)
  );

  // channel 0 = I (cosine), channel 1 = Q (sine)
  generate
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
      localparam logic [PW-1:0] START = (ch == 0) ? PW'(QM_COS_START) : PW'(QM_SIN_START);
      qmix_nco #(.PW(PW), .START(START)) u_nco (
        .clk(clk), .rst(rst), .load(load), .step(step), .lo_bit(lo_bit[ch])
      );
      assign mix_bit[ch] = rf_bit ^ lo_bit[ch];
      qmix_tally #(.WW(WW), .CW(CW)) u_tally (
        .clk(clk), .rst(rst), .mix_bit(mix_bit[ch]), .word_done(word_done),
        .cnt_two(c_two[ch]), .cnt_one(c_one[ch])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_vld <= 1'b0;
      snap_i   <= '0;
      snap_q   <= '0;
    end else begin
      snap_vld <= snap;
      if (snap) begin
        snap_i <= 32'({c_two[0], c_one[0]});
        snap_q <= 32'({c_two[1], c_one[1]});
      end
    end
  end

  // R6: one valid cycle per strobe
  assert_vld_follows_R6: assert property (@(posedge clk) disable iff (rst)
    snap |=> snap_vld);
  assert_vld_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !snap |=> !snap_vld);
  // R7: both channel words come from the same edge
  assert_same_edge_R7: assert property (@(posedge clk) disable iff (rst)
    snap |=> (snap_i == 32'($past({c_two[0], c_one[0]})) &&
              snap_q == 32'($past({c_two[1], c_one[1]}))));
  // R6: snapshot words hold while no strobe arrives
  assert_snap_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !snap |=> ($stable(snap_i) && $stable(snap_q)));

  initial begin
    assert_geometry_R3: assert (WW % 4 == 0 && WW >= 8 && SW == 32);
  end
endmodule

// File: tb/sim_onebit_qmix.sv
`timescale 1ns/1ps
module sim_onebit_qmix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rf_bit = 1'b0;
  logic        tune_we = 1'b0;
  logic [31:0] tune_step = '0;
  logic        snap = 1'b0;
  logic        snap_vld;
  logic [31:0] snap_i, snap_q;

  always #10 clk = ~clk;

  onebit_qmix u0 (
    .clk(clk), .rst(rst), .rf_bit(rf_bit), .tune_we(tune_we), .tune_step(tune_step),
    .snap(snap), .snap_vld(snap_vld), .snap_i(snap_i), .snap_q(snap_q)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string cur_req = "R9";

  // behavioural reference
  bit [31:0] m_pc, m_ps, m_step, m_pend_step;
  bit        m_pend;
  bit [15:0] m_y [2];
  bit [15:0] m_x [2];
  bit        q_i[$];
  bit        q_q[$];
  bit        e_vld;
  bit [31:0] e_i, e_q;

  task automatic model_reset();
    m_pc = 32'hC000_0000; m_ps = 32'h0; m_step = 32'h1000_0000;
    m_pend = 0; m_pend_step = 0;
    for (int c = 0; c < 2; c++) begin m_y[c] = 0; m_x[c] = 0; end
    q_i.delete(); q_q.delete();
    e_vld = 0; e_i = 0; e_q = 0;
  endtask

  task automatic fold(int c, ref bit q[$]);
    for (int g = 0; g < 8; g++) begin
      int ones = 0;
      for (int b = 0; b < 4; b++) ones += q[4*g + b];
      m_y[c] = m_y[c] - 16'(ones / 2);
      m_x[c] = m_x[c] - 16'(ones % 2);
    end
    q.delete();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) model_reset();
    else begin
      bit full, ld;
      e_vld = snap;
      if (snap) begin
        e_i = {m_y[0], m_x[0]};
        e_q = {m_y[1], m_x[1]};
      end
      q_i.push_back(rf_bit ^ m_pc[31]);
      q_q.push_back(rf_bit ^ m_ps[31]);
      full = (q_i.size() == 32);
      if (full) begin fold(0, q_i); fold(1, q_q); end
      ld = full && m_pend;
      if (ld) begin
        m_pc = 32'hC000_0000; m_ps = 32'h0; m_step = m_pend_step;
      end else begin
        m_pc = m_pc + m_step; m_ps = m_ps + m_step;
      end
      if (ld) m_pend = 0;
      if (tune_we) begin m_pend = 1; m_pend_step = tune_step; end
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, "snap_vld", 32'(snap_vld), 32'(e_vld));
      check(cur_req, "snap_i",   snap_i, e_i);
      check(cur_req, "snap_q",   snap_q, e_q);
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected under 60000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // pat: 0 random, 1 zeros, 2 ones, 3 alternating; snap_every 0 = never
  task automatic run(int n, int pat, int snap_every, string tag);
    cur_req = tag;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (pat)
        0: rf_bit = 1'($urandom);
        1: rf_bit = 1'b0;
        2: rf_bit = 1'b1;
        default: rf_bit = 1'(k);
      endcase
      snap = (snap_every > 0) && (k % snap_every == 0);
    end
  endtask

  task automatic tune(logic [31:0] s);
    @(negedge clk);
    tune_we = 1'b1; tune_step = s; rf_bit = 1'($urandom); snap = 1'b0;
    @(negedge clk);
    tune_we = 1'b0;
  endtask

  // write so that the write cycle is the one completing a word
  task automatic tune_on_boundary(logic [31:0] s);
    while (q_i.size() != 30) @(negedge clk);
    tune(s);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9: values during and right after reset
    check("R9", "reset snap_vld", 32'(snap_vld), 32'h0);
    check("R9", "reset snap_i", snap_i, 32'h0);
    check("R9", "reset snap_q", snap_q, 32'h0);
    rst = 1'b0;
    snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
    check("R9", "first snapshot I", snap_i, 32'h0);
    check("R9", "first snapshot Q", snap_q, 32'h0);
    run(200, 1, 16, "R1");   // zeros: counts follow the oscillators alone
    run(200, 2, 16, "R3");   // ones: inverted oscillators
    run(200, 3, 8,  "R3");   // alternating input
    run(400, 0, 13, "R4");   // random input, counters wrap over time
    run(100, 0, 1,  "R5");   // strobe every cycle: holds between words
    run(300, 0, 7,  "R6");
    run(96,  0, 32, "R7");
    cur_req = "R8";
    tune(32'h0123_4567);     // mid-word write
    run(70, 0, 5, "R8");
    tune_on_boundary(32'h4000_0000); // waits one more word
    run(80, 1, 4, "R8");
    tune(32'h2000_0000);
    tune(32'h0800_0000);     // overwrites the pending write
    run(120, 1, 6, "R8");
    tune(32'h8000_0000);     // half-rate oscillator from fresh phases
    run(200, 0, 11, "R2");
    tune(32'h0);             // frozen phases: cosine 1, sine 0
    run(200, 3, 9, "R2");
    run(1500, 0, 17, "R4");
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule